// File: doc/BRIEF.md
# Programmable Tap Delay Controller

The block delays a single-bit input stream by a whole number of clock cycles, chosen through a 10-bit tap word and added to a fixed base latency. It behaves like a fine-step delay line built from synchronous logic. A shift-register pipeline holds the input history, and a registered multiplexer picks the tap that matches the effective step count.

The select inputs are the tap word and a cascade bit. They pass straight through while the load-enable input is low and are frozen once it rises. Two override inputs force the shortest or the longest delay. The longest delay is one step beyond the all-ones tap word. An output-disable input holds the delayed output low. The latched cascade bit drives a pair of complementary outputs, so a second stage can be extended when a longer range is needed.

Top module: `tap_delay_ctrl`

## Requirements
- R1: With no override active, a single-cycle pulse on `din` appears on `dout` exactly BASE_LAT + N rising edges after the edge that samples it, where N is the unsigned value of `tap_sel` (bit 0 least significant) and BASE_LAT defaults to 2.
- R2: While `load_en` is low, `tap_sel` and `casc_sel` are transparent: a new value sets the delay and cascade state used from the next clock edge on.
- R3: The select values present at the last clock edge with `load_en` low are held while `load_en` stays high, and changes on `tap_sel` and `casc_sel` during that time have no effect.
- R4: With `force_min` high, the step count is 0 and the delay is BASE_LAT, whatever the tap word holds.
- R5: With `force_max` high and `force_min` low, the step count is 2^TAP_W (1024), one step more than the all-ones tap word.
- R6: With both `force_min` and `force_max` high, `force_min` wins and the delay is BASE_LAT.
- R7: `casc_out` equals the effective cascade bit one clock edge after it is sampled, and `casc_out_n` is always its complement.
- R8: After a clock edge that samples `out_dis` high, `dout` is low, and input pulses do not reach it.
- R9: A synchronous active-low reset clears the held select value to zero, flushes the pipeline, and drives `dout` and `casc_out` low and `casc_out_n` high.
- R10: A one-cycle input pulse comes out as a one-cycle output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay step per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| din | input | 1 | Input stream to delay |
| tap_sel | input | TAP_W | Requested step count |
| casc_sel | input | 1 | Requested cascade state |
| load_en | input | 1 | Low: selects transparent; high: selects held |
| force_min | input | 1 | Override to zero steps (highest priority) |
| force_max | input | 1 | Override to 2^TAP_W steps |
| out_dis | input | 1 | High forces `dout` low |
| dout | output | 1 | Delayed stream |
| casc_out | output | 1 | Cascade state |
| casc_out_n | output | 1 | Complement of `casc_out` |

## Verification
The bench measures the delay of single-cycle pulses at the two ends of the tap range, at 1023, and with each override alone and both together. A design that drops the extra step on the max override would give 1023 steps there. One that lets the max override win over the min override would give 1024 steps where none are expected. The hold tests change the tap word and cascade bit while `load_en` is high, which catches a latch that stays transparent. They also check that the value captured is the one present before the rise. A reset taken while ones are in flight must leave no stray output pulse afterwards. With output disable high, no pulse may reach `dout` at all.

// File: rtl/tdc_pkg.sv
// Shared types for the tap delay controller.
// Assumes: nothing beyond IEEE 1800-2017 packages.
package tdc_pkg;
    // Which override, if any, governs the step count.
    typedef enum logic [1:0] {
        OVR_NONE = 2'd0,
        OVR_MIN  = 2'd1,
        OVR_MAX  = 2'd2
    } ovr_e;
endpackage

// File: rtl/tdc_sel_hold.sv
// Select hold stage. It is transparent while load_en is low and holds the
// value captured at the last clock edge with load_en low while load_en is high.
// Assumes: the inputs are synchronous to clk.
module tdc_sel_hold #(
    parameter int TAP_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [TAP_W-1:0] tap_in,
    input  logic             casc_in,
    output logic [TAP_W-1:0] tap_eff,
    output logic             casc_eff
);
    logic [TAP_W-1:0] tap_hold;
    logic             casc_hold;

    // Track the live selects while open; keep them once load_en is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap_hold  <= '0;
            casc_hold <= 1'b0;
        end else if (!load_en) begin
            tap_hold  <= tap_in;
            casc_hold <= casc_in;
        end
    end

    // Open: pass the live value; held: present the stored value.
    always_comb begin
        tap_eff  = load_en ? tap_hold  : tap_in;
        casc_eff = load_en ? casc_hold : casc_in;
    end
endmodule

// File: rtl/tdc_tap_resolve.sv
// Override resolver. It applies min/max priority to the effective tap word
// and registers the step count and the cascade state.
// Assumes: force_min outranks force_max; the max override is one step
// beyond the all-ones tap word.
module tdc_tap_resolve
    import tdc_pkg::*;
#(
    parameter int TAP_W = 10,
    localparam int STEP_W = TAP_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TAP_W-1:0]  tap_eff,
    input  logic              casc_eff,
    input  logic              force_min,
    input  logic              force_max,
    output logic [STEP_W-1:0] steps_q,
    output logic              casc_q
);
    ovr_e              mode;
    logic [STEP_W-1:0] steps_d;

    // Pick the governing override in fixed priority order.
    always_comb begin
        if (force_min)      mode = OVR_MIN;
        else if (force_max) mode = OVR_MAX;
        else                mode = OVR_NONE;
    end

    // Map the mode to a step count.
    always_comb begin
        unique case (mode)
            OVR_MIN: steps_d = '0;
            OVR_MAX: steps_d = {1'b1, {TAP_W{1'b0}}};
            default: steps_d = {1'b0, tap_eff};
        endcase
    end

    // Register the step count and the cascade state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            steps_q <= '0;
            casc_q  <= 1'b0;
        end else begin
            steps_q <= steps_d;
            casc_q  <= casc_eff;
        end
    end
endmodule

// File: rtl/tdc_delay_line.sv
// Delay pipeline. A shift register records the input history, and a
// registered tap multiplexer drives the output. The total latency is
// BASE_LAT + steps edges.
// Assumes: BASE_LAT >= 1; steps <= 2**TAP_W.
module tdc_delay_line #(
    parameter int TAP_W    = 10,
    parameter int BASE_LAT = 2,
    localparam int STEP_W  = TAP_W + 1,
    localparam int DEPTH   = (1 << TAP_W) + BASE_LAT,
    localparam int IDX_W   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic              out_dis,
    input  logic [STEP_W-1:0] steps,
    output logic              dout
);
    logic [DEPTH-1:0] hist;
    logic [IDX_W-1:0] idx;
    logic             dout_q;

    // Shift the input history by one stage per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) hist <= '0;
        else        hist <= {hist[DEPTH-2:0], din};
    end

    // Tap index: one register stage is spent in the output flop.
    always_comb begin
        idx = IDX_W'(steps) + IDX_W'(BASE_LAT - 1);
    end

    // Register the selected tap, gated by the output disable.
    always_ff @(posedge clk) begin
        if (!rst_n)       dout_q <= 1'b0;
        else if (out_dis) dout_q <= 1'b0;
        else              dout_q <= hist[idx];
    end

    assign dout = dout_q;
endmodule

// File: rtl/tap_delay_ctrl.sv
// Top level of the programmable tap delay controller: select hold,
// override resolver and delay pipeline.
// Assumes: a single clock domain and synchronous active-low reset.
module tap_delay_ctrl #(
    parameter int TAP_W    = 10,
    parameter int BASE_LAT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             din,
    input  logic [TAP_W-1:0] tap_sel,
    input  logic             casc_sel,
    input  logic             load_en,
    input  logic             force_min,
    input  logic             force_max,
    input  logic             out_dis,
    output logic             dout,
    output logic             casc_out,
    output logic             casc_out_n
);
    localparam int STEP_W = TAP_W + 1;

    logic [TAP_W-1:0]  tap_eff;
    logic              casc_eff;
    logic [STEP_W-1:0] steps_q;
    logic              casc_q;

    tdc_sel_hold #(.TAP_W(TAP_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_en  (load_en),
        .tap_in   (tap_sel),
        .casc_in  (casc_sel),
        .tap_eff  (tap_eff),
        .casc_eff (casc_eff)
    );

    tdc_tap_resolve #(.TAP_W(TAP_W)) u_resolve (
        .clk       (clk),
        .rst_n     (rst_n),
        .tap_eff   (tap_eff),
        .casc_eff  (casc_eff),
        .force_min (force_min),
        .force_max (force_max),
        .steps_q   (steps_q),
        .casc_q    (casc_q)
    );

    tdc_delay_line #(.TAP_W(TAP_W), .BASE_LAT(BASE_LAT)) u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .out_dis (out_dis),
        .steps   (steps_q),
        .dout    (dout)
    );

    // Complementary cascade pair.
    assign casc_out   = casc_q;
    assign casc_out_n = ~casc_q;
endmodule

// File: rtl/tap_delay_ctrl_chk.sv
// Checker for tap_delay_ctrl, attached with bind. It observes ports only.
module tap_delay_ctrl_chk #(
    parameter int TAP_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic [TAP_W-1:0] tap_sel,
    input logic             casc_sel,
    input logic             load_en,
    input logic             out_dis,
    input logic             dout,
    input logic             casc_out,
    input logic             casc_out_n
);
    logic [1:0] warm;

    // Count the cycles since reset so that $past stays inside them.
    always_ff @(posedge clk) begin
        if (!rst_n)          warm <= 2'd0;
        else if (warm != 2'd3) warm <= warm + 2'd1;
    end

    // R7
    casc_follow_chk: assert property (@(posedge clk) disable iff (!rst_n || warm == 2'd0)
        !load_en |=> (casc_out == $past(casc_sel)));

    // R7
    casc_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (casc_out_n != casc_out));

    // R3
    casc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || warm < 2'd3)
        ($past(load_en) && $past(load_en, 2)) |-> $stable(casc_out));

    // R8
    out_dis_chk: assert property (@(posedge clk) disable iff (!rst_n || warm == 2'd0)
        $past(out_dis) |-> !dout);

    // R9
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (!dout && !casc_out && casc_out_n));
endmodule

bind tap_delay_ctrl tap_delay_ctrl_chk #(.TAP_W(TAP_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tap_sel    (tap_sel),
    .casc_sel   (casc_sel),
    .load_en    (load_en),
    .out_dis    (out_dis),
    .dout       (dout),
    .casc_out   (casc_out),
    .casc_out_n (casc_out_n)
);

// File: tb/tb_tap_delay_ctrl.sv
module tb_tap_delay_ctrl;
    localparam int TAP_W    = 10;
    localparam int BASE_LAT = 2;
    localparam int NOPULSE  = 1200;
    localparam int NV       = 9;
    localparam int V_TAP [NV] = '{0, 1, 2, 37, 512, 1023, 5, 700, 1023};
    localparam int V_MIN [NV] = '{0, 0, 0, 0,  0,   0,    0, 1,   1};
    localparam int V_MAX [NV] = '{0, 0, 0, 0,  0,   0,    1, 0,   1};
    localparam int V_STEP[NV] = '{0, 1, 2, 37, 512, 1023, 1024, 0, 0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic din = 1'b0;
    logic [TAP_W-1:0] tap_sel = '0;
    logic casc_sel = 1'b0, load_en = 1'b0, force_min = 1'b0, force_max = 1'b0, out_dis = 1'b0;
    logic dout, casc_out, casc_out_n;
    int n_run = 0, n_fail = 0, cyc = 0;

    always #4 clk = ~clk;

    tap_delay_ctrl #(.TAP_W(TAP_W), .BASE_LAT(BASE_LAT)) dut (
        .clk(clk), .rst_n(rst_n), .din(din), .tap_sel(tap_sel), .casc_sel(casc_sel),
        .load_en(load_en), .force_min(force_min), .force_max(force_max),
        .out_dis(out_dis), .dout(dout), .casc_out(casc_out), .casc_out_n(casc_out_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Flush, send a one-cycle pulse, count edges until it leaves; report width.
    task automatic measure(output int lat, output int wid);
        din = 1'b0;
        repeat (1100) @(negedge clk);
        din = 1'b1;
        @(posedge clk);
        @(negedge clk);
        din = 1'b0;
        lat = 0;
        while (!dout && lat < NOPULSE) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        wid = 0;
        while (dout && wid < 8) begin
            @(posedge clk);
            wid++;
            @(negedge clk);
        end
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_fail++;
                $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
                $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        int lat, wid;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 dout in reset", int'(dout), 0);
        chk("R9 casc_out in reset", int'(casc_out), 0);
        chk("R9 casc_out_n in reset", int'(casc_out_n), 1);
        rst_n = 1'b1;

        // Vector table: tap word, overrides, expected step count
        for (int i = 0; i < NV; i++) begin
            string req;
            tap_sel   = TAP_W'(V_TAP[i]);
            force_min = V_MIN[i][0];
            force_max = V_MAX[i][0];
            if (V_MIN[i] != 0 && V_MAX[i] != 0) req = "R6 both overrides";
            else if (V_MIN[i] != 0)              req = "R4 min override";
            else if (V_MAX[i] != 0)              req = "R5 max override";
            else                                 req = "R1 tap delay";
            measure(lat, wid);
            chk(req, lat, BASE_LAT + V_STEP[i]);
            if (i == 3) chk("R10 pulse width", wid, 1);
        end
        force_min = 1'b0;
        force_max = 1'b0;

        // R2 transparent follow
        tap_sel = 10'd9;
        measure(lat, wid);
        chk("R2 transparent tap", lat, BASE_LAT + 9);

        // R3 capture then ignore changes
        tap_sel = 10'd7;
        @(posedge clk); @(negedge clk);
        load_en = 1'b1;
        tap_sel = 10'd300;
        measure(lat, wid);
        chk("R3 held tap", lat, BASE_LAT + 7);
        load_en = 1'b0;
        measure(lat, wid);
        chk("R2 reopened tap", lat, BASE_LAT + 300);

        // R7 cascade pair, R3 cascade hold
        casc_sel = 1'b1;
        @(posedge clk); @(negedge clk);
        chk("R7 casc_out high", int'(casc_out), 1);
        chk("R7 casc_out_n low", int'(casc_out_n), 0);
        load_en = 1'b1;
        casc_sel = 1'b0;
        repeat (3) @(negedge clk);
        chk("R3 cascade held", int'(casc_out), 1);
        load_en = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R7 casc_out low", int'(casc_out), 0);
        chk("R7 casc_out_n high", int'(casc_out_n), 1);

        // R8 output disable
        tap_sel = 10'd3;
        out_dis = 1'b1;
        measure(lat, wid);
        chk("R8 disabled no pulse", lat, NOPULSE);
        out_dis = 1'b0;
        measure(lat, wid);
        chk("R8 re-enabled", lat, BASE_LAT + 3);

        // R9 reset flushes pipeline and clears held select
        tap_sel = 10'd600;
        din = 1'b1;
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        load_en = 1'b1;
        tap_sel = 10'd500;
        casc_sel = 1'b1;
        din = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        begin
            int seen = 0;
            for (int k = 0; k < 1100; k++) begin
                @(negedge clk);
                if (dout) seen++;
            end
            chk("R9 pipeline flushed", seen, 0);
        end
        chk("R9 cascade cleared", int'(casc_out), 0);
        measure(lat, wid);
        chk("R9 held select cleared", lat, BASE_LAT);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule